// File: doc/BRIEF.md
# Answer-to-Reset Structure Parser

This block walks the variable-length structure of a smart card's answer to reset, one decoded byte at a time, starting with the byte that follows the initial character. A start strobe arms it. Each byte that arrives while it is armed is classified from the presence bitmaps seen so far. The first byte is the format byte. The block tracks which interface bytes of the current group are still owed, how many historical bytes remain, and whether a closing check byte is due. It also reports, with one registered strobe per byte, which kind of byte it just consumed and whether that byte is globally qualified.

While bytes are classified, the parameters the card proposes are captured. These are the clock-rate conversion factor, the baud-adjust factor, the maximum clock frequency, the extra guard time, the set of offered protocols and the specific-mode flag. Defaults apply wherever the card is silent or uses a reserved code. When the structure is exhausted the block pulses done. If the structure still demands bytes once the length limit is reached, it pulses error instead. Bit reception and later protocol selection live elsewhere.

Top module: `atr_parser`

## Requirements
- R1: The first accepted byte after start is the format byte. Its bits 3:0 set hist_count, and bits 4, 5, 6 and 7 announce TA1, TB1, TC1 and TD1, which are then consumed in that order, followed by hist_count historical bytes.
- R2: A TD byte's bits 7:4 announce TA, TB, TC and TD of the next group in the same way. Its bits 3:0 give a protocol number T. For T from 0 to 14 it sets bit T of proto_mask, and bit 15 is never set. Bytes of the group following a TD with T=15 report kind_global=1. Group 1 bytes and TA2 always report kind_global=1. Format, historical and check bytes report 0.
- R3: TA1 sets the output fields from its two nibbles. The high nibble sets fi_val and fmax_half_mhz (frequency in 0.5 MHz units), mapping 0→372/8, 1→372/10, 2→558/12, 3→744/16, 4→1116/24, 5→1488/32, 6→1860/40, 9→512/10, 10→768/15, 11→1024/20, 12→1536/30 and 13→2048/40. The low nibble sets di_val, mapping 1→1, 2→2, 3→4, 4→8, 5→16, 6→32, 7→64, 8→12 and 9→20. A reserved high nibble gives 372/8 and a reserved low nibble gives 1.
- R4: After reset and after each start: fi_val=372, di_val=1, fmax_half_mhz=8, guard_n=0, proto_mask=0, specific_mode=0, hist_count=0, check_ok=0 and check_err=0.
- R5: TC1 loads guard_n with its 8-bit value. TC bytes of later groups leave guard_n unchanged.
- R6: TB1 is consumed as an interface byte but changes no captured field.
- R7: specific_mode becomes 1 when a TA2 byte is consumed.
- R8: A check byte is expected after the historical bytes only if some TD byte carried T≠0. check_ok=1 when it equals the XOR of all bytes from the format byte up to the byte just before it, and check_err=1 otherwise. Both stay 0 when no check byte was expected.
- R9: done pulses for one cycle in the cycle after the edge that consumed the last byte of the structure. Bytes arriving afterwards are ignored (no kind_valid, no field change) until the next start.
- R10: If the structure still demands bytes when the 32nd byte after the initial character is consumed, error pulses for one cycle in the following cycle instead of done, and the parser stops. done and error are never high together.
- R11: Each consumed byte gives a one-cycle kind_valid in the following cycle, with kind_code 1=format, 2=TA, 3=TB, 4=TC, 5=TD, 6=historical, 7=check.
- R12: A start, even in the middle of a structure, abandons it, restores the defaults and expects a new format byte. A byte presented in the same cycle as start is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Arms the parser for a new structure |
| byte_valid | input | 1 | byte_data carries a byte this cycle |
| byte_data | input | 8 | Decoded byte value |
| kind_valid | output | 1 | A byte was consumed on the previous edge |
| kind_code | output | 3 | Class of the consumed byte |
| kind_global | output | 1 | Consumed interface byte is global |
| fi_val | output | 12 | Clock-rate conversion factor |
| di_val | output | 7 | Baud-adjust factor |
| fmax_half_mhz | output | 6 | Maximum clock frequency in 0.5 MHz units |
| guard_n | output | 8 | Extra guard time |
| proto_mask | output | 16 | One bit per offered protocol number |
| specific_mode | output | 1 | Specific mode selected |
| hist_count | output | 4 | Number of historical bytes announced |
| check_ok | output | 1 | Check byte matched |
| check_err | output | 1 | Check byte mismatched |
| done | output | 1 | Structure completed |
| error | output | 1 | Structure exceeded the length limit |

## Verification
A wrong pending bitmap or historical counter changes the class of the very next byte, so it shows on kind_code one cycle after that byte. It usually also moves done early or late by a whole byte. A wrong running XOR or check-expected flag stays hidden until the last byte, where check_ok and check_err show it together with done. A broken length counter shows only at the 32-byte boundary, as an error where done was due or a done where error was due.

// File: rtl/atr_pkg.sv
// Shared types and decode functions for the answer-to-reset parser.
// Assumes bytes are already bit-ordered and polarity-corrected.
package atr_pkg;

    localparam int BYTE_W  = 8;
    localparam int NIB_W   = 4;
    localparam int FI_W    = 12;
    localparam int DI_W    = 7;
    localparam int FMAX_W  = 6;
    localparam int PROTO_N = 16;

    localparam logic [FI_W-1:0]   FI_DEFAULT   = 12'd372;
    localparam logic [DI_W-1:0]   DI_DEFAULT   = 7'd1;
    localparam logic [FMAX_W-1:0] FMAX_DEFAULT = 6'd8;

    typedef enum logic [2:0] {
        K_NONE = 3'd0,
        K_FMT  = 3'd1,
        K_TA   = 3'd2,
        K_TB   = 3'd3,
        K_TC   = 3'd4,
        K_TD   = 3'd5,
        K_HIST = 3'd6,
        K_TCK  = 3'd7
    } kind_e;

    // Clock-rate factor from the high TA1 nibble; 0 marks a reserved code.
    function automatic logic [FI_W-1:0] fi_of(input logic [NIB_W-1:0] c);
        case (c)
            4'd0, 4'd1: fi_of = 12'd372;
            4'd2:       fi_of = 12'd558;
            4'd3:       fi_of = 12'd744;
            4'd4:       fi_of = 12'd1116;
            4'd5:       fi_of = 12'd1488;
            4'd6:       fi_of = 12'd1860;
            4'd9:       fi_of = 12'd512;
            4'd10:      fi_of = 12'd768;
            4'd11:      fi_of = 12'd1024;
            4'd12:      fi_of = 12'd1536;
            4'd13:      fi_of = 12'd2048;
            default:    fi_of = '0;
        endcase
    endfunction

    // Maximum clock in half-MHz units from the high TA1 nibble; 0 = reserved.
    function automatic logic [FMAX_W-1:0] fmax_of(input logic [NIB_W-1:0] c);
        case (c)
            4'd0:        fmax_of = 6'd8;
            4'd1, 4'd9:  fmax_of = 6'd10;
            4'd2:        fmax_of = 6'd12;
            4'd3:        fmax_of = 6'd16;
            4'd4:        fmax_of = 6'd24;
            4'd5:        fmax_of = 6'd32;
            4'd6, 4'd13: fmax_of = 6'd40;
            4'd10:       fmax_of = 6'd15;
            4'd11:       fmax_of = 6'd20;
            4'd12:       fmax_of = 6'd30;
            default:     fmax_of = '0;
        endcase
    endfunction

    // Baud-adjust factor from the low TA1 nibble; 0 marks a reserved code.
    function automatic logic [DI_W-1:0] di_of(input logic [NIB_W-1:0] c);
        case (c)
            4'd1:    di_of = 7'd1;
            4'd2:    di_of = 7'd2;
            4'd3:    di_of = 7'd4;
            4'd4:    di_of = 7'd8;
            4'd5:    di_of = 7'd16;
            4'd6:    di_of = 7'd32;
            4'd7:    di_of = 7'd64;
            4'd8:    di_of = 7'd12;
            4'd9:    di_of = 7'd20;
            default: di_of = '0;
        endcase
    endfunction

endpackage

// File: rtl/atr_seq.sv
// Structure sequencer: classifies each incoming byte from the presence
// bitmaps, historical count and check-byte need, and ends the structure.
// Assumes start has priority over a byte presented in the same cycle.
module atr_seq
    import atr_pkg::*;
#(
    parameter int MAX_LEN = 32,
    localparam int CNT_W  = $clog2(MAX_LEN + 1),
    localparam int GRP_W  = $clog2(MAX_LEN + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              take,
    output kind_e             kind_now,
    output logic              in_grp1,
    output logic              in_grp2,
    output logic              kind_valid,
    output logic [2:0]        kind_code,
    output logic              kind_global,
    output logic              done,
    output logic              error
);

    logic             active, fmt_next, need_tck, qual15;
    logic [3:0]       pend, pend_n;
    logic [NIB_W-1:0] hist_left, hist_n;
    logic             need_n, more, glob_now;
    logic [CNT_W-1:0] cnt;
    logic [GRP_W-1:0] grp;

    // Class of the byte that would be consumed now.
    always_comb begin
        if (fmt_next)              kind_now = K_FMT;
        else if (pend[0])          kind_now = K_TA;
        else if (pend[1])          kind_now = K_TB;
        else if (pend[2])          kind_now = K_TC;
        else if (pend[3])          kind_now = K_TD;
        else if (hist_left != '0)  kind_now = K_HIST;
        else                       kind_now = K_TCK;
    end

    assign take    = active && byte_valid && !start;
    assign in_grp1 = (grp == GRP_W'(1));
    assign in_grp2 = (grp == GRP_W'(2));

    // Pending state after the current byte, and whether more is owed.
    always_comb begin
        pend_n = pend;
        hist_n = hist_left;
        need_n = need_tck;
        case (kind_now)
            K_FMT: begin
                pend_n = byte_data[7:4];
                hist_n = byte_data[3:0];
            end
            K_TA:   pend_n[0] = 1'b0;
            K_TB:   pend_n[1] = 1'b0;
            K_TC:   pend_n[2] = 1'b0;
            K_TD: begin
                pend_n = byte_data[7:4];
                need_n = need_tck | (byte_data[3:0] != '0);
            end
            K_HIST: hist_n = hist_left - 1'b1;
            default: ;
        endcase
        more = (pend_n != '0) || (hist_n != '0) || (need_n && kind_now != K_TCK);
    end

    // Interface bytes of group 1, TA2, and groups after a T=15 are global.
    always_comb begin
        glob_now = 1'b0;
        if (kind_now inside {K_TA, K_TB, K_TC, K_TD})
            glob_now = in_grp1 || qual15 || (in_grp2 && kind_now == K_TA);
    end

    // Sequencer state: armed flag, bitmaps, counters, group index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            fmt_next  <= 1'b0;
            pend      <= '0;
            hist_left <= '0;
            need_tck  <= 1'b0;
            qual15    <= 1'b0;
            cnt       <= '0;
            grp       <= '0;
        end else if (start) begin
            active    <= 1'b1;
            fmt_next  <= 1'b1;
            pend      <= '0;
            hist_left <= '0;
            need_tck  <= 1'b0;
            qual15    <= 1'b0;
            cnt       <= '0;
            grp       <= '0;
        end else if (take) begin
            fmt_next  <= 1'b0;
            pend      <= pend_n;
            hist_left <= hist_n;
            need_tck  <= need_n;
            cnt       <= cnt + 1'b1;
            if (kind_now == K_FMT) begin
                grp    <= GRP_W'(1);
                qual15 <= 1'b0;
            end else if (kind_now == K_TD) begin
                grp    <= grp + 1'b1;
                qual15 <= (byte_data[3:0] == 4'hF);
            end
            if (!more || cnt == CNT_W'(MAX_LEN - 1))
                active <= 1'b0;
        end
    end

    // Registered per-byte report and end strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_valid  <= 1'b0;
            kind_code   <= K_NONE;
            kind_global <= 1'b0;
            done        <= 1'b0;
            error       <= 1'b0;
        end else begin
            kind_valid  <= take;
            kind_code   <= take ? kind_now : K_NONE;
            kind_global <= take && glob_now;
            done        <= take && !more;
            error       <= take && more && (cnt == CNT_W'(MAX_LEN - 1));
        end
    end

endmodule

// File: rtl/atr_fields.sv
// Field capture: holds the parameters announced by format, TA1, TC1, TD
// and TA2 bytes. Assumes classification comes from the sequencer.
module atr_fields
    import atr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                take,
    input  kind_e               kind_now,
    input  logic                in_grp1,
    input  logic                in_grp2,
    input  logic [BYTE_W-1:0]   byte_data,
    output logic [FI_W-1:0]     fi_val,
    output logic [DI_W-1:0]     di_val,
    output logic [FMAX_W-1:0]   fmax_half_mhz,
    output logic [BYTE_W-1:0]   guard_n,
    output logic [PROTO_N-1:0]  proto_mask,
    output logic                specific_mode,
    output logic [NIB_W-1:0]    hist_count
);

    logic [FI_W-1:0]   fi_dec;
    logic [DI_W-1:0]   di_dec;
    logic [FMAX_W-1:0] fmax_dec;
    logic              fi_rsvd;

    // Decode TA1 nibbles, substituting defaults for reserved codes.
    always_comb begin
        fi_dec   = fi_of(byte_data[7:4]);
        fmax_dec = fmax_of(byte_data[7:4]);
        di_dec   = di_of(byte_data[3:0]);
        fi_rsvd  = (fi_dec == '0);
        if (fi_rsvd) begin
            fi_dec   = FI_DEFAULT;
            fmax_dec = FMAX_DEFAULT;
        end
        if (di_dec == '0) di_dec = DI_DEFAULT;
    end

    // Captured parameters, restored to defaults on reset and start.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            fi_val        <= FI_DEFAULT;
            di_val        <= DI_DEFAULT;
            fmax_half_mhz <= FMAX_DEFAULT;
            guard_n       <= '0;
            proto_mask    <= '0;
            specific_mode <= 1'b0;
            hist_count    <= '0;
        end else if (take) begin
            case (kind_now)
                K_FMT: hist_count <= byte_data[3:0];
                K_TA: begin
                    if (in_grp1) begin
                        fi_val        <= fi_dec;
                        di_val        <= di_dec;
                        fmax_half_mhz <= fmax_dec;
                    end
                    if (in_grp2) specific_mode <= 1'b1;
                end
                K_TC: if (in_grp1) guard_n <= byte_data;
                K_TD: if (byte_data[3:0] != 4'hF)
                          proto_mask[byte_data[3:0]] <= 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/atr_xor.sv
// Running XOR over consumed bytes and the final check-byte comparison.
// Assumes the check byte, when present, is the last byte consumed.
module atr_xor
    import atr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              take,
    input  kind_e             kind_now,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              check_ok,
    output logic              check_err
);

    logic [BYTE_W-1:0] acc;

    // Accumulate non-check bytes; compare when the check byte arrives.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            acc       <= '0;
            check_ok  <= 1'b0;
            check_err <= 1'b0;
        end else if (take) begin
            if (kind_now == K_TCK) begin
                check_ok  <= (acc == byte_data);
                check_err <= (acc != byte_data);
            end else begin
                acc <= acc ^ byte_data;
            end
        end
    end

endmodule

// File: rtl/atr_parser.sv
// Top of the answer-to-reset structure parser: sequencer, field capture
// and check-byte unit. Expects one byte per byte_valid after a start.
module atr_parser
    import atr_pkg::*;
#(
    parameter int MAX_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        byte_valid,
    input  logic [7:0]  byte_data,
    output logic        kind_valid,
    output logic [2:0]  kind_code,
    output logic        kind_global,
    output logic [11:0] fi_val,
    output logic [6:0]  di_val,
    output logic [5:0]  fmax_half_mhz,
    output logic [7:0]  guard_n,
    output logic [15:0] proto_mask,
    output logic        specific_mode,
    output logic [3:0]  hist_count,
    output logic        check_ok,
    output logic        check_err,
    output logic        done,
    output logic        error
);

    logic  take, in_grp1, in_grp2;
    kind_e kind_now;

    atr_seq #(.MAX_LEN(MAX_LEN)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .take(take), .kind_now(kind_now),
        .in_grp1(in_grp1), .in_grp2(in_grp2),
        .kind_valid(kind_valid), .kind_code(kind_code),
        .kind_global(kind_global), .done(done), .error(error)
    );

    atr_fields u_fields (
        .clk(clk), .rst_n(rst_n), .start(start), .take(take),
        .kind_now(kind_now), .in_grp1(in_grp1), .in_grp2(in_grp2),
        .byte_data(byte_data),
        .fi_val(fi_val), .di_val(di_val), .fmax_half_mhz(fmax_half_mhz),
        .guard_n(guard_n), .proto_mask(proto_mask),
        .specific_mode(specific_mode), .hist_count(hist_count)
    );

    atr_xor u_xor (
        .clk(clk), .rst_n(rst_n), .start(start), .take(take),
        .kind_now(kind_now), .byte_data(byte_data),
        .check_ok(check_ok), .check_err(check_err)
    );

endmodule

// File: rtl/atr_parser_chk.sv
// Port-level checker for the answer-to-reset parser, bound to the top.
module atr_parser_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        byte_valid,
    input logic        kind_valid,
    input logic [2:0]  kind_code,
    input logic        kind_global,
    input logic [11:0] fi_val,
    input logic [6:0]  di_val,
    input logic [7:0]  guard_n,
    input logic        specific_mode,
    input logic        check_ok,
    input logic        check_err,
    input logic        done,
    input logic        error
);

    assert_end_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_error_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> !error);

    assert_check_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(check_ok && check_err));

    assert_check_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(check_ok) || $rose(check_err)) |-> (done && kind_code == 3'd7));

    assert_defaults_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start) |-> (fi_val == 12'd372 && di_val == 7'd1 &&
                          guard_n == 8'd0 && !specific_mode && !kind_valid));

    assert_kind_follows_byte_R11: assert property (@(posedge clk) disable iff (!rst_n)
        kind_valid |-> ($past(byte_valid) && !$past(start)));

    assert_spec_by_ta2_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(specific_mode) |-> (kind_valid && kind_code == 3'd2 && kind_global));

    assert_guard_by_tc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(guard_n) |-> ((kind_valid && kind_code == 3'd4) || $past(start)));

    assert_fi_by_ta_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fi_val) |-> ((kind_valid && kind_code == 3'd2) || $past(start)));

endmodule

bind atr_parser atr_parser_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_valid(byte_valid),
    .kind_valid(kind_valid), .kind_code(kind_code), .kind_global(kind_global),
    .fi_val(fi_val), .di_val(di_val), .guard_n(guard_n),
    .specific_mode(specific_mode), .check_ok(check_ok),
    .check_err(check_err), .done(done), .error(error)
);

// File: tb/atr_parser_bench.sv
// Directed bench for the answer-to-reset parser; one task per scenario.
module atr_parser_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        kind_valid, kind_global, specific_mode;
    logic [2:0]  kind_code;
    logic [11:0] fi_val;
    logic [6:0]  di_val;
    logic [5:0]  fmax_half_mhz;
    logic [7:0]  guard_n;
    logic [15:0] proto_mask;
    logic [3:0]  hist_count;
    logic        check_ok, check_err, done, error;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    atr_parser u_atr_parser (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_valid(byte_valid),
        .byte_data(byte_data), .kind_valid(kind_valid), .kind_code(kind_code),
        .kind_global(kind_global), .fi_val(fi_val), .di_val(di_val),
        .fmax_half_mhz(fmax_half_mhz), .guard_n(guard_n),
        .proto_mask(proto_mask), .specific_mode(specific_mode),
        .hist_count(hist_count), .check_ok(check_ok), .check_err(check_err),
        .done(done), .error(error)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Start strobe for one cycle; outputs sampled at the following negedge.
    task automatic do_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    // One byte for one cycle; its registered results are visible on return.
    task automatic send(input logic [7:0] b);
        @(negedge clk) begin byte_valid = 1'b1; byte_data = b; end
        @(negedge clk) byte_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R4 reset fi", fi_val, 372);
        chk("R4 reset di", di_val, 1);
        chk("R4 reset fmax", fmax_half_mhz, 8);
        chk("R4 reset guard", guard_n, 0);
        chk("R4 reset mask", proto_mask, 0);
        chk("R4 reset ends", {done, error, check_ok, check_err, kind_valid}, 0);
    endtask

    task automatic t_minimal();
        do_start();
        send(8'h00);
        chk("R11 minimal kind", {kind_valid, kind_code}, {1'b1, 3'd1});
        chk("R9 minimal done", {done, error}, 2'b10);
        chk("R8 minimal no check", {check_ok, check_err}, 0);
        @(negedge clk);
        chk("R9 done one cycle", done, 0);
    endtask

    task automatic t_ta1_hist();
        do_start();
        send(8'h13);
        chk("R1 hist count", hist_count, 3);
        send(8'hB5);
        chk("R11 TA1 kind", {kind_code, kind_global}, {3'd2, 1'b1});
        chk("R3 fi B5", fi_val, 1024);
        chk("R3 di B5", di_val, 16);
        chk("R3 fmax B5", fmax_half_mhz, 20);
        send(8'h01);
        send(8'h02);
        chk("R1 hist kind", kind_code, 6);
        chk("R9 not done early", done, 0);
        send(8'h03);
        chk("R9 done after hist", done, 1);
    endtask

    task automatic t_tb1_ignored();
        do_start();
        send(8'h20);
        send(8'hFF);
        chk("R6 TB1 kind", kind_code, 3);
        chk("R6 TB1 fields", {fi_val, di_val, fmax_half_mhz, guard_n, specific_mode},
            {12'd372, 7'd1, 6'd8, 8'd0, 1'b0});
        chk("R6 TB1 done", done, 1);
    endtask

    task automatic t_tc1();
        do_start();
        send(8'h40);
        send(8'h2A);
        chk("R5 guard", guard_n, 42);
        chk("R5 done", done, 1);
    endtask

    task automatic t_tck(input logic [7:0] tck, input logic good);
        do_start();
        send(8'h81);
        send(8'h11);
        chk("R2 TD1 kind", {kind_code, kind_global}, {3'd5, 1'b1});
        send(8'h80);
        chk("R7 TA2 global", {kind_code, kind_global}, {3'd2, 1'b1});
        chk("R7 specific mode", specific_mode, 1);
        chk("R3 TA2 leaves fi", fi_val, 372);
        send(8'h55);
        chk("R8 check pending", done, 0);
        send(tck);
        chk("R8 check kind", kind_code, 7);
        chk("R8 check result", {check_ok, check_err}, good ? 2'b10 : 2'b01);
        chk("R8 done with check", done, 1);
        chk("R2 mask T1", proto_mask, 16'h0002);
    endtask

    task automatic t_global15();
        do_start();
        send(8'h80);
        send(8'h8F);
        send(8'h40);
        chk("R2 TD2 after T15 global", {kind_code, kind_global}, {3'd5, 1'b1});
        send(8'h07);
        chk("R2 TC3 specific", {kind_code, kind_global}, {3'd4, 1'b0});
        chk("R5 TC3 no guard", guard_n, 0);
        chk("R2 mask no bit15", proto_mask, 16'h0001);
        send(8'h48);
        chk("R8 T15 check", {done, check_ok}, 2'b11);
        do_start();
        send(8'h80);
        send(8'h00);
        chk("R8 T0 only no check", {done, check_ok, check_err}, 3'b100);
    endtask

    task automatic t_reserved();
        do_start();
        send(8'h10);
        send(8'h7A);
        chk("R3 reserved defaults", {fi_val, di_val, fmax_half_mhz}, {12'd372, 7'd1, 6'd8});
        do_start();
        send(8'h10);
        send(8'h98);
        chk("R3 code 98", {fi_val, di_val, fmax_half_mhz}, {12'd512, 7'd12, 6'd10});
    endtask

    task automatic t_exact_max();
        do_start();
        send(8'h8F);
        for (int i = 0; i < 15; i++) send(8'h80);
        send(8'h00);
        for (int i = 0; i < 14; i++) send(8'hA5);
        chk("R10 31 bytes no end", {done, error}, 0);
        send(8'hA5);
        chk("R10 32 bytes done", {done, error}, 2'b10);
    endtask

    task automatic t_overflow();
        do_start();
        send(8'h80);
        for (int i = 0; i < 30; i++) send(8'h80);
        chk("R10 before limit", {done, error}, 0);
        send(8'h80);
        chk("R10 overflow error", {done, error}, 2'b01);
        send(8'h40);
        chk("R9 ignored after error", {kind_valid, error}, 0);
    endtask

    task automatic t_restart();
        do_start();
        send(8'h13);
        send(8'h11);
        chk("R3 fi 11", di_val, 1);
        do_start();
        chk("R12 restart defaults", {fi_val, hist_count}, {12'd372, 4'd0});
        @(negedge clk) begin start = 1'b1; byte_valid = 1'b1; byte_data = 8'h40; end
        @(negedge clk) begin start = 1'b0; byte_valid = 1'b0; end
        chk("R12 byte with start ignored", kind_valid, 0);
        send(8'h00);
        chk("R12 new format", {kind_code, done}, {3'd1, 1'b1});
        send(8'h40);
        chk("R9 idle ignored", {kind_valid, guard_n}, {1'b0, 8'd0});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_minimal();
        t_ta1_hist();
        t_tb1_ignored();
        t_tc1();
        t_tck(8'h45, 1'b1);
        t_tck(8'h46, 1'b0);
        t_global15();
        t_reserved();
        t_exact_max();
        t_overflow();
        t_restart();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule